// File: doc/BRIEF.md
# Receive Word Queue Read Port

This block buffers incoming 32-bit receive words in a small queue and presents the head word to software through a four-register memory-mapped window. The register bus carries a word address, four byte enables, separate read and write strobes and registered read data. Reads of 8, 16 or 32 bits are all legal. Each read returns the enabled byte lanes of the word at the head of the queue.

Software chooses at run time how the queue advances. In automatic mode, every read of the data register removes the head word, whatever the access width. Any bytes that the read did not cover are lost. In manual mode, data reads have no side effect, so a word can be gathered in narrow pieces. Software then discards the word by writing a command bit. A status register reports empty, full and the fill level. It also holds sticky error flags for reads or commands on an empty queue and for pushes into a full queue.

Top module: `rxq_read_port`

## Requirements
- R1: A read of the data register (bus_addr 0) returns, one cycle after the read strobe, the head word's bytes in the lanes whose byte enable is set, with zeros in the other lanes.
- R2: With the mode bit (bus_addr 1, bit 0) at 1, any read of the data register of any width removes the head word, so the next read returns the following word.
- R3: With the mode bit at 0, reads of the data register leave the queue unchanged, and repeated reads return lanes of the same word.
- R4: In manual mode, writing 1 to bit 0 of the command register (bus_addr 2) removes the head word. The command register always reads as zero. In automatic mode the command has no effect.
- R5: A command write takes effect only when byte enables 0 and 1 are both set. A write with either of them clear leaves the queue unchanged.
- R6: On an empty queue, a data read returns zero and removes nothing, and a manual command removes nothing. Either event sets the sticky underflow flag (status bit 3).
- R7: The queue holds DEPTH (16) words. A push while full is dropped, and it sets the sticky overflow flag (status bit 2).
- R8: The status register (bus_addr 3) reads empty in bit 0, full in bit 1, overflow in bit 2, underflow in bit 3 and the fill count in bits 8:4. The same empty, full and count values appear on the status output ports. Writing 1 to bit 2 or bit 3 with byte enable 0 set clears that flag.
- R9: After reset the mode bit reads 1, the queue is empty and both sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push one word into the queue |
| push_data | input | 32 | Word to push |
| bus_addr | input | 2 | Register word address |
| bus_be | input | 4 | Byte enables |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |
| q_count | output | 5 | Words held |

## Verification
A wrong read pointer or fill count shows up as a wrong word on the read following the faulty access, and so one bus transaction later. A lane-mask or width-decode error corrupts the very read that exposes it. Mode or command-gating faults show up as the count on q_count either moving when it should hold or holding when it should move. A lost sticky flag is visible on the next status read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_CMD  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int S_EMPTY = 0;
  localparam int S_FULL  = 1;
  localparam int S_OVF   = 2;
  localparam int S_UDF   = 3;
  localparam int S_CNT   = 4;
endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: fill level never exceeds capacity
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R7: a push into a full queue changes nothing when no pop happens
  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop |=> count == CW'(DEPTH));
endmodule

// File: rtl/rxq_decode.sv
module rxq_decode
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic [1:0]        addr,
  input  logic [NB-1:0]     be,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              data_rd,
  output logic              cmd_adv,
  output logic              mode_we,
  output logic              clr_ovf,
  output logic              clr_udf,
  output logic [DATA_W-1:0] lane_mask
);
  assign data_rd = rd && (addr == A_DATA);
  // command needs the two low lanes together
  assign cmd_adv = wr && (addr == A_CMD) && be[0] && be[1] && wdata[0];
  assign mode_we = wr && (addr == A_MODE) && be[0];
  assign clr_ovf = wr && (addr == A_STAT) && be[0] && wdata[S_OVF];
  assign clr_udf = wr && (addr == A_STAT) && be[0] && wdata[S_UDF];

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_mask[8*i +: 8] = {8{be[i]}};
  end
endmodule

// File: rtl/rxq_read_port.sv
module rxq_read_port
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int NB = DATA_W / 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic [1:0]        bus_addr,
  input  logic [NB-1:0]     bus_be,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              q_empty,
  output logic              q_full,
  output logic [CW-1:0]     q_count
);
  logic              data_rd, cmd_adv, mode_we, clr_ovf, clr_udf;
  logic [DATA_W-1:0] lane_mask, head, stat_word, rd_next;
  logic              auto_mode, ovf_flag, udf_flag;
  logic              pop_rd, pop_cmd, underflow, overflow;

  rxq_decode #(.DATA_W(DATA_W)) i_dec (
    .addr(bus_addr), .be(bus_be), .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata),
    .data_rd(data_rd), .cmd_adv(cmd_adv), .mode_we(mode_we),
    .clr_ovf(clr_ovf), .clr_udf(clr_udf), .lane_mask(lane_mask)
  );

  assign pop_rd    = data_rd && auto_mode && !q_empty;
  assign pop_cmd   = cmd_adv && !auto_mode && !q_empty;
  assign underflow = (data_rd && q_empty) || (cmd_adv && !auto_mode && q_empty);
  assign overflow  = push_valid && q_full;

  rxq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .push(push_valid), .din(push_data),
    .pop(pop_rd || pop_cmd), .head(head),
    .empty(q_empty), .full(q_full), .count(q_count)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[S_EMPTY] = q_empty;
    stat_word[S_FULL]  = q_full;
    stat_word[S_OVF]   = ovf_flag;
    stat_word[S_UDF]   = udf_flag;
    stat_word[S_CNT +: CW] = q_count;
    case (bus_addr)
      A_DATA:  rd_next = q_empty ? '0 : (head & lane_mask);
      A_MODE:  rd_next = DATA_W'(auto_mode) & lane_mask;
      A_STAT:  rd_next = stat_word & lane_mask;
      default: rd_next = '0;
    endcase
  end

  // data is captured from the old head on the same edge that pops it
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      auto_mode <= 1'b1;
      ovf_flag  <= 1'b0;
      udf_flag  <= 1'b0;
    end else begin
      if (bus_rd)  bus_rdata <= rd_next;
      if (mode_we) auto_mode <= bus_wdata[0];
      if (overflow)     ovf_flag <= 1'b1;
      else if (clr_ovf) ovf_flag <= 1'b0;
      if (underflow)    udf_flag <= 1'b1;
      else if (clr_udf) udf_flag <= 1'b0;
    end
  end

  // R2: automatic-mode read of a non-empty queue takes one word
  p_auto_pop_r2: assert property (@(posedge clk) disable iff (rst)
    data_rd && auto_mode && !q_empty && !push_valid && !mode_we
    |=> q_count == $past(q_count) - 1'b1);
  // R3: manual-mode read without command leaves count alone
  p_manual_hold_r3: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == A_DATA && !auto_mode && !bus_wr && !push_valid
    |=> $stable(q_count));
  // R4: command register reads back as zero
  p_cmd_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == A_CMD |=> bus_rdata == '0);
  // R5: narrow command write is ignored
  p_narrow_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == A_CMD && !(bus_be[0] && bus_be[1]) && !bus_rd && !push_valid
    |=> $stable(q_count));
  // R6: empty data read returns zero and raises underflow
  p_empty_read_r6: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == A_DATA && q_empty |=> bus_rdata == '0 && udf_flag);
endmodule

// File: tb/test_rxq_read_port.sv
module test_rxq_read_port;
  localparam time CLK = 4ns;
  logic clk = 0, rst = 1;
  logic push_valid = 0;
  logic [31:0] push_data = '0;
  logic [1:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic q_empty, q_full;
  logic [4:0] q_count;
  int checks = 0, errors = 0;

  always #(CLK/2) clk = ~clk;

  rxq_read_port i_rxq_read_port (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .q_empty(q_empty), .q_full(q_full), .q_count(q_count)
  );

  typedef struct packed {
    logic [1:0]  kind;  // 0 push, 1 read, 2 write
    logic [1:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 4'h0, 32'h11223344, 32'h0, 8'd1},
    '{2'd0, 2'd0, 4'h0, 32'h55667788, 32'h0, 8'd1},
    '{2'd0, 2'd0, 4'h0, 32'h99AABBCC, 32'h0, 8'd1},
    '{2'd0, 2'd0, 4'h0, 32'hDDEEFF00, 32'h0, 8'd1},
    '{2'd1, 2'd0, 4'hF, 32'h0, 32'h11223344, 8'd1},   // R1 full word, R2 pop
    '{2'd1, 2'd0, 4'h1, 32'h0, 32'h00000088, 8'd2},   // R2 byte read still pops
    '{2'd1, 2'd0, 4'hC, 32'h0, 32'h99AA0000, 8'd1},   // R1 upper half
    '{2'd2, 2'd1, 4'h1, 32'h0, 32'h0, 8'd3},          // manual mode
    '{2'd1, 2'd0, 4'h2, 32'h0, 32'h0000FF00, 8'd3},   // R3
    '{2'd1, 2'd0, 4'h8, 32'h0, 32'hDD000000, 8'd3},   // R3 same word
    '{2'd2, 2'd2, 4'h1, 32'h1, 32'h0, 8'd5},          // R5 narrow command
    '{2'd1, 2'd0, 4'hF, 32'h0, 32'hDDEEFF00, 8'd5},   // R5 word still there
    '{2'd2, 2'd2, 4'h3, 32'h1, 32'h0, 8'd4},          // R4 advance
    '{2'd1, 2'd2, 4'hF, 32'h0, 32'h0, 8'd4},          // R4 reads zero
    '{2'd1, 2'd3, 4'hF, 32'h0, 32'h00000001, 8'd8},   // R8 empty, count 0
    '{2'd1, 2'd0, 4'hF, 32'h0, 32'h0, 8'd6},          // R6 empty read
    '{2'd1, 2'd3, 4'hF, 32'h0, 32'h00000009, 8'd6},   // R6 underflow set
    '{2'd2, 2'd3, 4'h1, 32'h8, 32'h0, 8'd8}           // R8 clear underflow
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); push_valid = 1; push_data = d;
    @(negedge clk); push_valid = 0;
  endtask

  task automatic bread(input logic [1:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_be = be; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  initial begin
    #(CLK * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    bread(2'd3, 4'hF, r); check("R9 status", r, 32'h1);
    bread(2'd1, 4'hF, r); check("R9 mode", r, 32'h1);
    check("R9 empty port", {31'b0, q_empty}, 32'h1);
    check("R9 count port", {27'b0, q_count}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        2'd0: push(VEC[i].data);
        2'd1: begin
          bread(VEC[i].addr, VEC[i].be, r);
          check($sformatf("R%0d vec %0d", VEC[i].req, i), r, VEC[i].exp);
        end
        default: bwrite(VEC[i].addr, VEC[i].be, VEC[i].data);
      endcase
    end
    bread(2'd3, 4'hF, r); check("R8 underflow cleared", r, 32'h1);

    // R7 fill past capacity in manual mode
    for (int i = 0; i < 17; i++) push(32'h1000 + i);
    bread(2'd3, 4'hF, r); check("R7 full with overflow", r, 32'h106);
    check("R8 full port", {31'b0, q_full}, 32'h1);
    // R5 upper-lane command ignored
    bwrite(2'd2, 4'hC, 32'h1);
    check("R5 count after upper-lane command", {27'b0, q_count}, 32'd16);
    // R4 command in automatic mode has no effect
    bwrite(2'd1, 4'h1, 32'h1);
    bwrite(2'd2, 4'hF, 32'h1);
    check("R4 command ignored in auto", {27'b0, q_count}, 32'd16);
    // R2 drain in order; 17th push was dropped
    for (int i = 0; i < 16; i++) begin
      bread(2'd0, 4'hF, r);
      check($sformatf("R2 drain %0d", i), r, 32'h1000 + i);
    end
    check("R7 dropped word absent", {27'b0, q_count}, 32'd0);
    bwrite(2'd3, 4'h1, 32'h4);
    bread(2'd3, 4'hF, r); check("R8 overflow cleared", r, 32'h1);
    // R6 manual command on empty
    bwrite(2'd1, 4'h1, 32'h0);
    bwrite(2'd2, 4'h3, 32'h1);
    bread(2'd3, 4'hF, r); check("R6 command on empty", r, 32'h9);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule